// File: doc/BRIEF.md
# Stream Receive Buffer with Late-Beat Absorption

This block sits on the application side of a packet stream whose source reacts slowly to back-pressure. After the block drops its ready output, the source can still deliver up to three valid beats. After ready rises again, the source can wait up to three clocks before it resumes, and it resumes only if it has more data. The block stores every beat the source presents, whether ready is high or low. Each stored beat keeps its data word, start-of-packet bit, end-of-packet bit and empty bit together. The beats come out on an ordinary valid/ready interface with zero ready latency.

On the input, `in_ready` is a hint to the source and not a gate: a beat is taken whenever `in_valid` is high. Ready is driven from the number of entries in use. It falls while at least `SKID` entries are still free, so the beats already in flight always fit. On the output, a beat moves only on a cycle where `out_valid` and `out_ready` are both high. While downstream stalls, the presented beat does not change. Packet boundaries are stored and passed on, but not interpreted. Valid may drop in the middle of a packet.

Top module: `rl_stream_rx_buf`

## Requirements
- R1: While `rst` is high, `in_ready` is 0. On the first cycle after `rst` falls, `out_valid` is 0 and `in_ready` is 1, and anything stored before the reset is gone.
- R2: Every cycle with `in_valid` high stores a beat, including the up to `SKID` (3) cycles after `in_ready` has fallen, so none of those beats is lost.
- R3: `in_ready` is 1 exactly when the number of stored beats is at most `DEPTH - SKID - 1`, that is, when more than 3 entries are free. It follows the occupancy on the cycle after the occupancy changes.
- R4: `out_valid` is 1 exactly when at least one beat is stored.
- R5: Beats leave in the order they were stored, with the data word unchanged.
- R6: The start-of-packet, end-of-packet and empty bits presented with each output beat are the ones captured with that beat's data. Empty = 1 means only the lower 64 bits are meaningful.
- R7: A beat is removed only on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the data and all flags hold steady.
- R8: On a cycle with `in_valid` low, nothing is stored, whatever values the data and flag inputs carry. This allows gaps inside a packet.
- R9: On a cycle where a beat is stored and another leaves, the occupancy does not change, even when the buffer is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_ready | output | 1 | Room hint to the source. Low when only `SKID` or fewer entries are free |
| in_valid | input | 1 | Source beat present. Always captured |
| in_data | input | DATA_W | Source data word (64 or 128 bits) |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_empty | input | 1 | Upper 64 bits unused on this beat |
| out_valid | output | 1 | A stored beat is presented |
| out_ready | input | 1 | Downstream accepts the presented beat |
| out_data | output | DATA_W | Presented data word |
| out_sop | output | 1 | Start-of-packet of the presented beat |
| out_eop | output | 1 | End-of-packet of the presented beat |
| out_empty | output | 1 | Empty bit of the presented beat |

## Verification
A table of beats is run first. It mixes in-packet gaps that carry junk flags, downstream stalls, simultaneous store and remove, and both values of the empty bit. This tells apart a buffer that really honours `in_valid` from one that samples the flags on every cycle, and it shows whether the flags stay with their data. The buffer is then filled with a permanent stall until ready falls, and three more late beats are sent. Counting the beats that drain out shows whether beats arriving after the drop are kept or lost. A store and a remove on a full buffer, followed by another full drain, separates a correct occupancy count from one that double counts. A reset in the middle of a run, with beats still stored, shows that the reset empties the buffer.

// File: rtl/rlbuf_pkg.sv
package rlbuf_pkg;
  localparam int FLAG_W = 3;

  typedef struct packed {
    logic sop;
    logic eop;
    logic empty;
  } beat_flags_t;

  function automatic int addr_w(input int depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/rlbuf_store.sv
module rlbuf_store #(
  parameter int WORD_W = 67,
  parameter int DEPTH  = 8,
  localparam int AW    = rlbuf_pkg::addr_w(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_word;
  end

  assign rd_word = cells[rd_addr];
endmodule

// File: rtl/rlbuf_ptrs.sv
module rlbuf_ptrs #(
  parameter int DEPTH = 8,
  localparam int AW   = rlbuf_pkg::addr_w(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty
);
  logic [AW-1:0] wr_nxt, rd_nxt;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign full  = (occ == CW'(DEPTH));
  assign empty = (occ == '0);
endmodule

// File: rtl/rl_stream_rx_buf.sv
module rl_stream_rx_buf #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8,
  parameter int SKID   = 3,
  localparam int AW     = rlbuf_pkg::addr_w(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int WORD_W = DATA_W + rlbuf_pkg::FLAG_W,
  localparam int LIMIT  = DEPTH - SKID - 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic              in_ready,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_empty,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_empty
);
  import rlbuf_pkg::*;

  beat_flags_t       in_flags, out_flags;
  logic [WORD_W-1:0] in_word, out_word;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     occ;
  logic              full, empty, push, pop;

  assign in_flags = '{sop: in_sop, eop: in_eop, empty: in_empty};
  assign in_word  = {in_data, in_flags};

  assign pop  = out_ready && !empty;
  assign push = in_valid && (!full || pop);

  rlbuf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk    (clk),
    .rst    (rst),
    .push   (push),
    .pop    (pop),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .occ    (occ),
    .full   (full),
    .empty  (empty)
  );

  rlbuf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (push),
    .wr_addr (wr_ptr),
    .wr_word (in_word),
    .rd_addr (rd_ptr),
    .rd_word (out_word)
  );

  assign in_ready  = !rst && (occ <= CW'(LIMIT));
  assign out_valid = !empty;
  assign out_flags = beat_flags_t'(out_word[FLAG_W-1:0]);
  assign out_data  = out_word[WORD_W-1:FLAG_W];
  assign out_sop   = out_flags.sop;
  assign out_eop   = out_flags.eop;
  assign out_empty = out_flags.empty;
endmodule

// File: rtl/rlbuf_checker.sv
module rlbuf_checker #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8,
  parameter int SKID   = 3,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              in_valid,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_sop,
  input logic              out_eop,
  input logic              out_empty,
  input logic [CW-1:0]     occ
);
  a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && in_ready));

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ((occ < CW'(DEPTH)) || out_ready));

  a_r3_ready_has_room: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (occ <= CW'(DEPTH - SKID - 1)));

  a_r4_empty_stays: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !in_valid) |=> !out_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_sop) && $stable(out_eop) && $stable(out_empty)));

  a_r8_idle_no_change: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !out_ready) |=> $stable(occ));

  a_r9_pushpop_level: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_valid && out_ready) |=> $stable(occ));
endmodule

bind rl_stream_rx_buf rlbuf_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SKID(SKID)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .out_empty (out_empty),
  .occ       (occ)
);

// File: tb/rl_stream_rx_buf_bench.sv
`timescale 1ns/1ps
module rl_stream_rx_buf_bench;
  localparam int DATA_W = 128;
  localparam int DEPTH  = 8;
  localparam int SKID   = 3;
  localparam int WORD_W = DATA_W + 3;
  localparam int TBL_N  = 16;
  // row bits: {valid, sop, eop, empty, out_ready}
  localparam logic [4:0] TBL [TBL_N] = '{
    5'b11001, // R6 packet start
    5'b01111, // R8 gap with junk flags
    5'b10001,
    5'b10111, // R6 end, empty=1
    5'b11100, // single-beat packet, stall
    5'b11000,
    5'b00000, // R8 gap under stall
    5'b10100,
    5'b00001,
    5'b11011, // R9 store and remove together
    5'b10001,
    5'b10101,
    5'b00001,
    5'b00001,
    5'b00001,
    5'b00001
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              in_ready, in_valid, in_sop, in_eop, in_empty;
  logic [DATA_W-1:0] in_data;
  logic              out_valid, out_ready, out_sop, out_eop, out_empty;
  logic [DATA_W-1:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  int n_out = 0;
  logic last_ready;
  logic [WORD_W-1:0] mq [$];

  always #2.5 clk = ~clk;

  rl_stream_rx_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SKID(SKID)) u_rl_stream_rx_buf (
    .clk(clk), .rst(rst), .in_ready(in_ready), .in_valid(in_valid),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty)
  );

  function automatic logic [DATA_W-1:0] mkdata(input int i);
    return {(DATA_W/32){32'hC0DE0000 + 32'(i)}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic sop, input logic eop, input logic emp,
                      input logic ordy, input logic [DATA_W-1:0] d);
    logic vv;
    logic exp_rdy;
    vv = v;
    @(negedge clk);
    if (vv && mq.size() == DEPTH && !ordy) vv = 1'b0;
    in_valid = vv; in_sop = sop; in_eop = eop; in_empty = emp;
    in_data = d; out_ready = ordy;
    #1;
    last_ready = in_ready;
    exp_rdy = (mq.size() <= DEPTH - SKID - 1);
    chk(in_ready === exp_rdy, "R3 ready vs occupancy", in_ready, exp_rdy);
    chk(out_valid === (mq.size() != 0), "R4 out_valid", out_valid, mq.size() != 0);
    if (mq.size() != 0) begin
      chk(out_data === mq[0][WORD_W-1:3], "R5 order/data", out_data, mq[0][WORD_W-1:3]);
      chk({out_sop, out_eop, out_empty} === mq[0][2:0], "R6 flags",
          {out_sop, out_eop, out_empty}, mq[0][2:0]);
      if (ordy) n_out++;
    end
    @(posedge clk);
    if (ordy && mq.size() != 0) void'(mq.pop_front());
    if (vv) mq.push_back({d, sop, eop, emp});
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] held;
    rst = 1'b1; in_valid = 0; in_sop = 0; in_eop = 0; in_empty = 0;
    in_data = '0; out_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 chk(in_ready === 1'b0, "R1 ready low in reset", in_ready, 1'b0);
    rst = 1'b0;
    #1;
    chk(out_valid === 1'b0, "R1 out_valid after reset", out_valid, 1'b0);
    chk(in_ready === 1'b1, "R1 ready after reset", in_ready, 1'b1);

    // table walk: gaps (R8), stalls (R7), mixed flags (R6), push+pop (R9)
    for (int i = 0; i < TBL_N; i++)
      step(TBL[i][4], TBL[i][3], TBL[i][2], TBL[i][1], TBL[i][0], mkdata(i));
    while (mq.size() != 0) step(0, 0, 0, 0, 1, '0);

    // R2: fill under stall until ready drops, then SKID late beats in total
    n_out = 0;
    last_ready = 1'b1;
    for (int i = 0; last_ready && i < DEPTH; i++)
      step(1, i == 0, 0, i[0], 0, mkdata(100 + i));
    for (int i = 0; i < SKID - 1; i++)
      step(1, 0, i == SKID - 2, 1, 0, mkdata(200 + i));
    chk(in_ready === 1'b0, "R2 ready low when full", in_ready, 1'b0);

    // R7: hold under stall
    held = out_data;
    step(0, 1, 1, 1, 0, '1);
    chk(out_data === held, "R7 data held while stalled", out_data, held);

    // R9: store and remove together on a full buffer
    step(1, 1, 1, 0, 1, mkdata(300));
    while (mq.size() != 0) step(0, 0, 0, 0, 1, '0);
    chk(n_out == DEPTH + 1, "R2/R9 beats drained", n_out, DEPTH + 1);

    // R1: reset with beats stored
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 0, mkdata(400 + i));
    @(negedge clk);
    in_valid = 0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mq.delete();
    #1;
    chk(out_valid === 1'b0, "R1 mid-run reset empties", out_valid, 1'b0);
    chk(in_ready === 1'b1, "R1 ready after mid-run reset", in_ready, 1'b1);
    step(0, 0, 0, 0, 1, '0);

    summary();
    $finish;
  end
endmodule